// File: doc/BRIEF.md
# System I/O and Sound-Processor Control Register File

This block is the byte-wide control register file that sits in the main processor's I/O window. It answers a 13-bit offset with a version byte that reports the board's region and timing, keeps a data byte and a direction byte for each of three controller ports, and owns the two handshake lines that the main processor uses to take over the sound processor: a bus request and a reset. It also takes in the sound processor's bus-grant line and returns it, inverted, to software.

Accesses are single-cycle strobes. Writes take effect at the clock edge that ends the strobe, and reads are answered combinationally in the same cycle. Both byte and word accesses are supported. Which byte lane a word write uses depends on the offset. A word read either copies the byte onto both lanes or fills the low lane from the open-bus value on an input. The controller-port bytes are presented on output buses for the pin logic next to this block. The region and timing flags come from input pins.

Top module: `sysio_ctrl_regs`

## Requirements
- R1: Offsets below 0x100 decode by word index (offset bits 7:1). Index 0 reads the version byte: bit 7 = `cfg_export`, bit 6 = `cfg_pal`, bit 5 = 1 (no expansion disk), bits 4:0 = 0, so a domestic 60 Hz board reads 0x20. Writes to index 0 change nothing.
- R2: Indices 1, 2 and 3 (offsets 0x02–0x07) are the data bytes of pads 0, 1 and 2. Each reads back the last byte written and drives `pad_data_o[8*k+7:8*k]` for pad k.
- R3: Indices 4, 5 and 6 (offsets 0x08–0x0D) are the direction bytes of pads 0, 1 and 2. Each reads back the last byte written and drives `pad_ctrl_o[8*k+7:8*k]`.
- R4: A byte read of any undecoded offset returns 0xFF. This covers indices 7 and up below 0x100, and every offset at 0x100 or above other than 0x1100 and 0x1200.
- R5: A write to offset 0x1100 sets `snd_busreq` to the written bit 0 from the next clock edge on.
- R6: A read of offset 0x1100 returns, in bit 0, the inverse of `snd_busack` as registered at the preceding clock edge. Bits 7:1 are `open_bus[15:9]`.
- R7: A write to offset 0x1200 with bit 0 = 1 deasserts `snd_reset`, and with bit 0 = 0 asserts it. A read returns bit 0 = NOT `snd_reset` and bits 7:1 = 0.
- R8: A byte write uses `wdata[7:0]`. A word write uses `wdata[7:0]` below offset 0x100 and `wdata[15:8]` at 0x100 or above.
- R9: A byte read returns the byte in `rdata[7:0]` with `rdata[15:8]` = 0. A word read below 0x100 returns the byte on both lanes. At 0x100 or above, a word read returns the byte in `rdata[15:8]` and `open_bus[7:0]` in `rdata[7:0]`.
- R10: While and after synchronous reset, `snd_reset` = 1, `snd_busreq` = 0, and all pad data and direction bytes are 0.
- R11: A write to an undecoded offset leaves every output and every readable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_ofs | input | 13 | Offset within the I/O window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the strobe cycle |
| open_bus | input | 16 | Open-bus value used for unfilled read bits |
| cfg_export | input | 1 | Region flag: export board |
| cfg_pal | input | 1 | Region flag: 50 Hz timing |
| snd_busack | input | 1 | Bus grant from the sound processor |
| snd_busreq | output | 1 | Bus request to the sound processor |
| snd_reset | output | 1 | Reset to the sound processor, active high |
| pad_data_o | output | 24 | Data bytes of the three pads |
| pad_ctrl_o | output | 24 | Direction bytes of the three pads |

## Verification
A wrong internal state shows up on the pad buses or on the two handshake lines at the first clock edge after the offending write. It can also show up in the same cycle as the next read of the affected offset. Decode faults, such as an index that aliases onto the wrong pad or an undecoded offset that accepts a write, are found by writing distinct values and then reading every neighbour. A fault in lane steering or in the open-bus merge shows up in a single word read. An error in the bus-grant sampling shows up one cycle after `snd_busack` changes.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    localparam int OFS_W    = 13;
    localparam int BYTE_W   = 8;
    localparam int NUM_PADS = 3;
    localparam int PAD_SELW = $clog2(NUM_PADS + 1);
    localparam int FLAT_W   = NUM_PADS * BYTE_W;

    localparam logic [OFS_W-1:0] LOW_AREA_END = 13'h0100;
    localparam logic [OFS_W-1:0] BUSREQ_OFS   = 13'h1100;
    localparam logic [OFS_W-1:0] SNDRST_OFS   = 13'h1200;
    localparam logic [BYTE_W-1:0] UNMAPPED    = 8'hFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_VERSION,
        SEL_PAD_DATA,
        SEL_PAD_DIR,
        SEL_BUSREQ,
        SEL_SNDRST
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e             kind;
        logic [PAD_SELW-1:0]   pad;
        logic                  low_area;
    } decode_t;

    function automatic logic [BYTE_W-1:0] version_byte(input logic export_f, input logic pal_f);
        return {export_f, pal_f, 1'b1, 5'b00000};
    endfunction

    function automatic logic [BYTE_W-1:0] write_lane(input logic [15:0] d, input logic word,
                                                     input logic low_area);
        return (word && !low_area) ? d[15:8] : d[7:0];
    endfunction

    function automatic logic [BYTE_W-1:0] grant_byte(input logic [15:0] ob, input logic ack);
        return {ob[15:9], ~ack};
    endfunction

    function automatic logic [15:0] read_lanes(input logic [BYTE_W-1:0] b, input logic word,
                                               input logic low_area, input logic [15:0] ob);
        if (!word)         return {8'h00, b};
        else if (low_area) return {b, b};
        else               return {b, ob[7:0]};
    endfunction

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
    import sysio_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    output decode_t          dec
);
    logic [6:0] idx;
    assign idx = ofs[7:1];

    always_comb begin
        dec          = '0;
        dec.kind     = SEL_NONE;
        dec.low_area = (ofs < LOW_AREA_END);
        if (dec.low_area) begin
            case (idx)
                7'd0:             dec.kind = SEL_VERSION;
                7'd1, 7'd2, 7'd3: begin
                    dec.kind = SEL_PAD_DATA;
                    dec.pad  = PAD_SELW'(idx[1:0] - 2'd1);
                end
                7'd4, 7'd5, 7'd6: begin
                    dec.kind = SEL_PAD_DIR;
                    dec.pad  = PAD_SELW'(idx[1:0]);
                end
                default:          dec.kind = SEL_NONE;
            endcase
        end else if (ofs == BUSREQ_OFS) begin
            dec.kind = SEL_BUSREQ;
        end else if (ofs == SNDRST_OFS) begin
            dec.kind = SEL_SNDRST;
        end
    end
endmodule

// File: rtl/sysio_pad_bank.sv
module sysio_pad_bank
    import sysio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic                 is_dir,
    input  logic [PAD_SELW-1:0]  pad,
    input  logic [BYTE_W-1:0]    wbyte,
    output logic [FLAT_W-1:0]    data_flat,
    output logic [FLAT_W-1:0]    dir_flat
);
    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        logic [BYTE_W-1:0] data_q;
        logic [BYTE_W-1:0] dir_q;
        logic              hit;

        assign hit = we && (pad == PAD_SELW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q <= '0;
                dir_q  <= '0;
            end else if (hit) begin
                if (is_dir) dir_q  <= wbyte;
                else        data_q <= wbyte;
            end
        end

        assign data_flat[g*BYTE_W +: BYTE_W] = data_q;
        assign dir_flat[g*BYTE_W +: BYTE_W]  = dir_q;
    end
endmodule

// File: rtl/sysio_snd_ctrl.sv
module sysio_snd_ctrl #(
    parameter int ACK_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_we,
    input  logic rst_we,
    input  logic wbit,
    input  logic busack_in,
    output logic busreq_o,
    output logic sndrst_o,
    output logic busack_s
);
    logic req_q;
    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            run_q <= 1'b0;
        end else begin
            if (req_we) req_q <= wbit;
            if (rst_we) run_q <= wbit;
        end
    end

    assign busreq_o = req_q;
    assign sndrst_o = ~run_q;

    if (ACK_STAGES <= 1) begin : g_ack1
        logic ack_q;
        always_ff @(posedge clk) begin
            if (rst) ack_q <= 1'b0;
            else     ack_q <= busack_in;
        end
        assign busack_s = ack_q;
    end else begin : g_ackn
        logic [ACK_STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[ACK_STAGES-2:0], busack_in};
        end
        assign busack_s = chain_q[ACK_STAGES-1];
    end
endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
    import sysio_pkg::*;
#(
    parameter int ACK_STAGES = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_en,
    input  logic                 acc_wr,
    input  logic                 acc_word,
    input  logic [OFS_W-1:0]     acc_ofs,
    input  logic [15:0]          wdata,
    output logic [15:0]          rdata,
    input  logic [15:0]          open_bus,
    input  logic                 cfg_export,
    input  logic                 cfg_pal,
    input  logic                 snd_busack,
    output logic                 snd_busreq,
    output logic                 snd_reset,
    output logic [FLAT_W-1:0]    pad_data_o,
    output logic [FLAT_W-1:0]    pad_ctrl_o
);
    decode_t           dec;
    logic              wr_cyc;
    logic [BYTE_W-1:0] wbyte;
    logic              ack_s;
    logic [BYTE_W-1:0] rbyte;
    logic [PAD_SELW-1:0] pad_c;

    sysio_decode u_dec (
        .ofs (acc_ofs),
        .dec (dec)
    );

    assign wr_cyc = acc_en && acc_wr;
    assign wbyte  = write_lane(wdata, acc_word, dec.low_area);

    sysio_pad_bank u_pads (
        .clk       (clk),
        .rst       (rst),
        .we        (wr_cyc && (dec.kind == SEL_PAD_DATA || dec.kind == SEL_PAD_DIR)),
        .is_dir    (dec.kind == SEL_PAD_DIR),
        .pad       (dec.pad),
        .wbyte     (wbyte),
        .data_flat (pad_data_o),
        .dir_flat  (pad_ctrl_o)
    );

    sysio_snd_ctrl #(.ACK_STAGES(ACK_STAGES)) u_snd (
        .clk       (clk),
        .rst       (rst),
        .req_we    (wr_cyc && dec.kind == SEL_BUSREQ),
        .rst_we    (wr_cyc && dec.kind == SEL_SNDRST),
        .wbit      (wbyte[0]),
        .busack_in (snd_busack),
        .busreq_o  (snd_busreq),
        .sndrst_o  (snd_reset),
        .busack_s  (ack_s)
    );

    assign pad_c = (dec.pad < PAD_SELW'(NUM_PADS)) ? dec.pad : '0;

    always_comb begin
        case (dec.kind)
            SEL_VERSION:  rbyte = version_byte(cfg_export, cfg_pal);
            SEL_PAD_DATA: rbyte = pad_data_o[pad_c*BYTE_W +: BYTE_W];
            SEL_PAD_DIR:  rbyte = pad_ctrl_o[pad_c*BYTE_W +: BYTE_W];
            SEL_BUSREQ:   rbyte = grant_byte(open_bus, ack_s);
            SEL_SNDRST:   rbyte = {7'b0000000, ~snd_reset};
            default:      rbyte = UNMAPPED;
        endcase
    end

    assign rdata = read_lanes(rbyte, acc_word, dec.low_area, open_bus);
endmodule

// File: rtl/sysio_ctrl_regs_chk.sv
module sysio_ctrl_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_en,
    input logic        acc_wr,
    input logic        acc_word,
    input logic [12:0] acc_ofs,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        snd_busreq,
    input logic        snd_reset,
    input logic [23:0] pad_data_o,
    input logic [23:0] pad_ctrl_o
);
    logic rst_d;
    logic sel_bit;
    always_ff @(posedge clk) rst_d <= rst;
    assign sel_bit = acc_word ? wdata[8] : wdata[0];

    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            assert_reset_state_R10: assert (snd_reset && !snd_busreq &&
                                             pad_data_o == 24'h0 && pad_ctrl_o == 24'h0)
                else $error("reset state wrong");
        end
    end

    assert_busreq_write_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_wr && acc_ofs == 13'h1100) |=> (snd_busreq == $past(sel_bit)));

    assert_sndrst_write_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_wr && acc_ofs == 13'h1200) |=> (snd_reset == !$past(sel_bit)));

    assert_hold_without_write_R11: assert property (@(posedge clk) disable iff (rst)
        !(acc_en && acc_wr) |=> ($stable(pad_data_o) && $stable(pad_ctrl_o) &&
                                 $stable(snd_busreq) && $stable(snd_reset)));

    assert_unmapped_low_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && !acc_word && acc_ofs < 13'h0100 && acc_ofs[7:1] >= 7'd7)
        |-> (rdata == 16'h00FF));

    assert_version_fixed_bits_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && !acc_word && acc_ofs < 13'h0002)
        |-> (rdata[5] && rdata[4:0] == 5'd0 && rdata[15:8] == 8'd0));

    assert_word_low_mirror_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && acc_word && acc_ofs < 13'h0100) |-> (rdata[15:8] == rdata[7:0]));
endmodule

bind sysio_ctrl_regs sysio_ctrl_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_word   (acc_word),
    .acc_ofs    (acc_ofs),
    .wdata      (wdata),
    .rdata      (rdata),
    .snd_busreq (snd_busreq),
    .snd_reset  (snd_reset),
    .pad_data_o (pad_data_o),
    .pad_ctrl_o (pad_ctrl_o)
);

// File: tb/tb_sysio_ctrl_regs.sv
module tb_sysio_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_word = 1'b0;
    logic [12:0] acc_ofs = '0;
    logic [15:0] wdata = '0, open_bus = '0;
    logic        cfg_export = 1'b0, cfg_pal = 1'b0, snd_busack = 1'b0;
    logic [15:0] rdata;
    logic        snd_busreq, snd_reset;
    logic [23:0] pad_data_o, pad_ctrl_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sysio_ctrl_regs dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_word(acc_word),
        .acc_ofs(acc_ofs), .wdata(wdata), .rdata(rdata), .open_bus(open_bus),
        .cfg_export(cfg_export), .cfg_pal(cfg_pal), .snd_busack(snd_busack),
        .snd_busreq(snd_busreq), .snd_reset(snd_reset),
        .pad_data_o(pad_data_o), .pad_ctrl_o(pad_ctrl_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare every read cycle against the scoreboard
    always @(negedge clk) begin
        if (!rst && acc_en && !acc_wr) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected read actual=%h expected=none", rdata);
            end else begin
                chk(tag_q.pop_front(), {16'h0, rdata}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic bus_wr(input logic [12:0] ofs, input logic word, input logic [15:0] d);
        @(posedge clk); #1;
        acc_en = 1'b1; acc_wr = 1'b1; acc_word = word; acc_ofs = ofs; wdata = d;
        @(posedge clk); #1;
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [12:0] ofs, input logic word, input logic [15:0] exp,
                          input string tag);
        @(posedge clk); #1;
        acc_en = 1'b1; acc_wr = 1'b0; acc_word = word; acc_ofs = ofs;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        acc_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R10 reset state
        chk("R10 snd_reset", {31'h0, snd_reset}, 32'h1);
        chk("R10 snd_busreq", {31'h0, snd_busreq}, 32'h0);
        chk("R10 pads", {8'h0, pad_data_o}, 32'h0);
        chk("R10 dirs", {8'h0, pad_ctrl_o}, 32'h0);
        bus_rd(13'h1200, 1'b0, 16'h0000, "R7 read after reset");

        // R1 version byte
        bus_rd(13'h0000, 1'b0, 16'h0020, "R1 domestic");
        cfg_export = 1'b1;
        bus_rd(13'h0001, 1'b0, 16'h00A0, "R1 export 60Hz");
        cfg_pal = 1'b1;
        bus_rd(13'h0000, 1'b1, 16'hE0E0, "R1 R9 export 50Hz word");
        cfg_pal = 1'b0;
        bus_wr(13'h0000, 1'b0, 16'h0055);
        bus_rd(13'h0000, 1'b0, 16'h00A0, "R1 write ignored");

        // R2 pad data bytes, aliasing of odd/even offsets
        bus_wr(13'h0003, 1'b0, 16'h0012);
        bus_wr(13'h0005, 1'b0, 16'h0034);
        bus_wr(13'h0006, 1'b0, 16'h0056);
        chk("R2 pad_data_o", {8'h0, pad_data_o}, 32'h00563412);
        bus_rd(13'h0002, 1'b0, 16'h0012, "R2 pad0");
        bus_rd(13'h0004, 1'b1, 16'h3434, "R2 R9 pad1 word");
        bus_rd(13'h0007, 1'b0, 16'h0056, "R2 pad2");

        // R3 direction bytes with R8 low-lane word writes
        bus_wr(13'h0008, 1'b1, 16'hAB40);
        bus_wr(13'h000A, 1'b0, 16'h007F);
        bus_wr(13'h000D, 1'b1, 16'h1122);
        chk("R3 R8 pad_ctrl_o", {8'h0, pad_ctrl_o}, 32'h00227F40);
        chk("R3 data untouched", {8'h0, pad_data_o}, 32'h00563412);
        bus_rd(13'h0009, 1'b0, 16'h0040, "R3 dir0");
        bus_rd(13'h000C, 1'b0, 16'h0022, "R3 dir2");

        // R4 undecoded reads
        open_bus = 16'h6B3C;
        bus_rd(13'h000E, 1'b0, 16'h00FF, "R4 index 7");
        bus_rd(13'h00FF, 1'b1, 16'hFFFF, "R4 R9 index 127 word");
        bus_rd(13'h1000, 1'b0, 16'h00FF, "R4 high undecoded");
        bus_rd(13'h1000, 1'b1, 16'hFF3C, "R4 R9 high undecoded word");
        bus_rd(13'h1101, 1'b0, 16'h00FF, "R4 near busreq");

        // R11 undecoded writes
        bus_wr(13'h000E, 1'b0, 16'h0000);
        bus_wr(13'h1101, 1'b1, 16'hFFFF);
        bus_wr(13'h1201, 1'b1, 16'hFFFF);
        bus_wr(13'h0F00, 1'b0, 16'h0001);
        chk("R11 pads kept", {8'h0, pad_data_o}, 32'h00563412);
        chk("R11 dirs kept", {8'h0, pad_ctrl_o}, 32'h00227F40);
        chk("R11 busreq kept", {31'h0, snd_busreq}, 32'h0);
        chk("R11 reset kept", {31'h0, snd_reset}, 32'h1);
        bus_rd(13'h000E, 1'b0, 16'h00FF, "R11 index 7 still unmapped");

        // R5 / R8 bus request
        bus_wr(13'h1100, 1'b0, 16'h0001);
        chk("R5 busreq set", {31'h0, snd_busreq}, 32'h1);
        bus_wr(13'h1100, 1'b1, 16'h0001);
        chk("R5 R8 word high lane 0", {31'h0, snd_busreq}, 32'h0);
        bus_wr(13'h1100, 1'b1, 16'h0100);
        chk("R5 R8 word high lane 1", {31'h0, snd_busreq}, 32'h1);

        // R6 grant readback
        snd_busack = 1'b0;
        bus_rd(13'h1100, 1'b0, 16'h006B, "R6 no grant");
        snd_busack = 1'b1;
        bus_rd(13'h1100, 1'b0, 16'h006A, "R6 granted");
        bus_rd(13'h1100, 1'b1, 16'h6A3C, "R6 R9 word");

        // R7 sound reset
        bus_wr(13'h1200, 1'b0, 16'h0001);
        chk("R7 release", {31'h0, snd_reset}, 32'h0);
        bus_rd(13'h1200, 1'b0, 16'h0001, "R7 read released");
        bus_rd(13'h1200, 1'b1, 16'h013C, "R7 R9 word");
        bus_wr(13'h1200, 1'b1, 16'h0001);
        chk("R7 R8 assert via high lane", {31'h0, snd_reset}, 32'h1);
        bus_wr(13'h1200, 1'b1, 16'h01FE);
        chk("R7 R8 release via high lane", {31'h0, snd_reset}, 32'h0);

        // R10 mid-run reset
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1;
        chk("R10 rerun reset", {31'h0, snd_reset}, 32'h1);
        chk("R10 rerun busreq", {31'h0, snd_busreq}, 32'h0);
        chk("R10 rerun pads", {8'h0, pad_data_o}, 32'h0);
        chk("R10 rerun dirs", {8'h0, pad_ctrl_o}, 32'h0);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R10 scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule